// File: doc/BRIEF.md
# Masked Interrupt Message Scheduler

This block converts per-vector interrupt events into single-DWORD posted memory writes. Every vector carries its own 64-bit target address and 32-bit payload, supplied by the surrounding logic as flat buses. A vector can be held off by its own mask bit. A function-wide mask holds off all vectors at once. An event that cannot be sent at once is remembered in a per-vector pending bit. The message goes out as soon as the vector is allowed to send, so an event raised under a mask is replayed after software lifts the mask.

A fixed arbiter picks among the sendable vectors, lowest index first. Only one message is in flight at a time. The write request leaves on a valid/ready channel, and the result comes back on a one-cycle completion strobe with a 2-bit status. Back-pressure rules on the request channel:
- `wr_valid` stays high with `wr_addr` and `wr_data` unchanged until a cycle in which `wr_ready` is high.
- That cycle is the handshake.
- `cpl_valid` is looked at only after a handshake and before the matching completion.

The block holds off a message that has been chosen but not yet offered if the vector becomes masked before it is offered again after a retry. It never withdraws a message that is already being offered.

Top module: `irq_msg_sched`

## Requirements
- R1: After reset `wr_valid` is low and no pending state exists, so no write appears until an event arrives.
- R2: An event pulse on an unmasked vector, with `enable` high, produces exactly one write. That write carries that vector's address (bits `[64*i +: 64]` of `vec_addr`), its data (bits `[32*i +: 32]` of `vec_data`) and `wr_be` = 4'hF.
- R3: No write for a vector is started while its own mask bit or `func_mask` is high.
- R4: An event on a masked vector sets its pending bit. After the mask is lifted, the vector is sent exactly once.
- R5: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold in the next cycle.
- R6: When several vectors can send in the same cycle, the lowest index is served first.
- R7: Completion status 2'b01 (retry) keeps the pending bit set. If the vector is still sendable, the same address and data are offered again in the next cycle.
- R8: Completion status 2'b00 (normal), 2'b10 (master abort) and 2'b11 (target abort) each count as sent. Each clears the pending bit, and no further write follows for that vector.
- R9: While `enable` is low, no new write is started and event pulses are dropped without effect. Pending bits set earlier are kept.
- R10: Several events on a vector before its message completes merge into one write. An event in the same cycle as that vector's completion leaves the vector pending, and it is sent again.
- R11: At most one write is outstanding. No new handshake occurs between a handshake and its completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global send and latch enable |
| func_mask | input | 1 | Masks every vector when high |
| vec_mask | input | NUM_VEC | Per-vector mask bits |
| event_pulse | input | NUM_VEC | One-cycle interrupt events, one per vector |
| vec_addr | input | NUM_VEC*64 | Flat per-vector target addresses |
| vec_data | input | NUM_VEC*32 | Flat per-vector payloads |
| wr_valid | output | 1 | Write request offered |
| wr_ready | input | 1 | Write request accepted this cycle |
| wr_addr | output | 64 | Write target address |
| wr_data | output | 32 | Write payload |
| wr_be | output | 4 | Byte enables, all set |
| cpl_valid | input | 1 | Completion strobe for the outstanding write |
| cpl_status | input | 2 | 00 normal, 01 retry, 10 master abort, 11 target abort |

## Verification
The hardest situations to reach from the ports are these:
- A new event landing on the very cycle its vector completes.
- A mask rising between a retry status and the re-offer.
- Several vectors becoming sendable together while the channel is stalled.

Directed sequences cover the plain cases with fixed ready and fixed status lists. The corner cases come from a long phase that randomizes all of the following every cycle:
- events on every vector
- mask flips
- `enable` drops
- ready gaps
- completion delays
- all four status codes

A behavioural model in the bench, built from queues and integers, predicts the request channel every cycle. It is compared against the design on every clock, so any of these collisions that happens is judged as it occurs.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

  typedef enum logic [1:0] {
    CPL_OK     = 2'b00,
    CPL_RETRY  = 2'b01,
    CPL_MABORT = 2'b10,
    CPL_TABORT = 2'b11
  } cpl_status_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'b00,
    ENG_ISSUE = 2'b01,
    ENG_WAIT  = 2'b10
  } eng_state_e;

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] set_vec,
  input  logic [NUM_VEC-1:0] clr_vec,
  output logic [NUM_VEC-1:0] pend
);

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[g] <= 1'b0;
      end else if (set_vec[g]) begin
        pend[g] <= 1'b1;
      end else if (clr_vec[g]) begin
        pend[g] <= 1'b0;
      end
    end

    // R4
    set_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[g] |=> pend[g]);

    // R8
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[g] && !set_vec[g]) |=> !pend[g]);

    // R10
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend[g] && !set_vec[g]) |=> !pend[g]);
  end

endmodule

// File: rtl/irq_lowest_arb.sv
module irq_lowest_arb #(
  parameter int NUM_VEC = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_VEC-1:0] req,
  output logic [NUM_VEC-1:0] grant,
  output logic [IDX_W-1:0]   grant_idx,
  output logic               any_req
);

  logic [NUM_VEC:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_chain
    assign grant[g]     = req[g] & ~blocked[g];
    assign blocked[g+1] = blocked[g] | req[g];
  end

  assign any_req = blocked[NUM_VEC];

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (grant[i]) grant_idx = IDX_W'(i);
    end
  end

  logic lower_seen;
  logic lower_bad;
  always_comb begin
    lower_seen = 1'b0;
    lower_bad  = 1'b0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (grant[i] && lower_seen) lower_bad = 1'b1;
      if (req[i]) lower_seen = 1'b1;
    end
    // R6
    single_grant_chk: assert ($onehot0(grant));
    // R6
    lowest_first_chk: assert (!lower_bad);
  end

endmodule

// File: rtl/irq_wr_engine.sv
module irq_wr_engine
  import irq_msg_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pick_valid,
  input  logic [IDX_W-1:0]  pick_idx,
  input  logic [ADDR_W-1:0] pick_addr,
  input  logic [DATA_W-1:0] pick_data,
  input  logic              cur_ok,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              done,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              cpl_valid,
  input  logic [1:0]        cpl_status
);

  eng_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  cpl_status_e       status;

  assign status = cpl_status_e'(cpl_status);

  always_comb begin
    state_d = state_q;
    done    = 1'b0;
    unique case (state_q)
      ENG_IDLE:  if (pick_valid) state_d = ENG_ISSUE;
      ENG_ISSUE: if (wr_ready) state_d = ENG_WAIT;
      ENG_WAIT: begin
        if (cpl_valid) begin
          if (status == CPL_RETRY) begin
            state_d = cur_ok ? ENG_ISSUE : ENG_IDLE;
          end else begin
            done    = 1'b1;
            state_d = ENG_IDLE;
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ENG_IDLE && pick_valid) begin
        idx_q  <= pick_idx;
        addr_q <= pick_addr;
        data_q <= pick_data;
      end
    end
  end

  assign wr_valid = (state_q == ENG_ISSUE);
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
  assign cur_idx  = idx_q;

  // R5
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R7
  retry_reoffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_WAIT && cpl_valid && status == CPL_RETRY && cur_ok)
      |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R11
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_valid);

endmodule

// File: rtl/irq_msg_sched.sv
module irq_msg_sched
  import irq_msg_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int ADDR_W  = 64,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic                      func_mask,
  input  logic [NUM_VEC-1:0]        vec_mask,
  input  logic [NUM_VEC-1:0]        event_pulse,
  input  logic [NUM_VEC*ADDR_W-1:0] vec_addr,
  input  logic [NUM_VEC*DATA_W-1:0] vec_data,
  output logic                      wr_valid,
  input  logic                      wr_ready,
  output logic [ADDR_W-1:0]         wr_addr,
  output logic [DATA_W-1:0]         wr_data,
  output logic [DATA_W/8-1:0]       wr_be,
  input  logic                      cpl_valid,
  input  logic [1:0]                cpl_status
);

  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int BE_W  = DATA_W / 8;

  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] sendable;
  logic [NUM_VEC-1:0] grant;
  logic [NUM_VEC-1:0] set_vec;
  logic [NUM_VEC-1:0] clr_vec;
  logic [NUM_VEC-1:0] cur_onehot;
  logic [IDX_W-1:0]   grant_idx;
  logic [IDX_W-1:0]   cur_idx;
  logic               any_req;
  logic               done;
  logic               cur_ok;
  logic [ADDR_W-1:0]  pick_addr;
  logic [DATA_W-1:0]  pick_data;

  assign set_vec  = event_pulse & {NUM_VEC{enable}};
  assign sendable = pend & ~vec_mask & {NUM_VEC{~func_mask & enable}};

  always_comb begin
    cur_onehot = '0;
    cur_onehot[cur_idx] = 1'b1;
  end

  assign clr_vec = cur_onehot & {NUM_VEC{done}};
  assign cur_ok  = |(sendable & cur_onehot);

  always_comb begin
    pick_addr = vec_addr[int'(grant_idx)*ADDR_W +: ADDR_W];
    pick_data = vec_data[int'(grant_idx)*DATA_W +: DATA_W];
  end

  irq_pend_bank #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .pend    (pend)
  );

  irq_lowest_arb #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_arb (
    .req       (sendable),
    .grant     (grant),
    .grant_idx (grant_idx),
    .any_req   (any_req)
  );

  irq_wr_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick_valid (any_req),
    .pick_idx   (grant_idx),
    .pick_addr  (pick_addr),
    .pick_data  (pick_data),
    .cur_ok     (cur_ok),
    .cur_idx    (cur_idx),
    .done       (done),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cpl_valid  (cpl_valid),
    .cpl_status (cpl_status)
  );

  assign wr_be = {BE_W{1'b1}};

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> (!$past(func_mask) && (($past(vec_mask) & cur_onehot) == '0)));

  // R9
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(enable));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !wr_valid);

  // R6
  grant_only_when_sendable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~sendable) == '0);

endmodule

// File: tb/irq_msg_sched_test.sv
`timescale 1ns/1ps
module irq_msg_sched_test;

  localparam int NV = 8;
  localparam int AW = 64;
  localparam int DW = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           enable = 1'b0;
  logic           func_mask = 1'b0;
  logic [NV-1:0]  vec_mask = '0;
  logic [NV-1:0]  event_pulse = '0;
  logic [NV*AW-1:0] vec_addr;
  logic [NV*DW-1:0] vec_data;
  logic           wr_valid;
  logic           wr_ready = 1'b1;
  logic [AW-1:0]  wr_addr;
  logic [DW-1:0]  wr_data;
  logic [3:0]     wr_be;
  logic           cpl_valid = 1'b0;
  logic [1:0]     cpl_status = 2'b00;

  always #2.5 clk = ~clk;

  irq_msg_sched #(.NUM_VEC(NV), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .func_mask(func_mask),
    .vec_mask(vec_mask), .event_pulse(event_pulse), .vec_addr(vec_addr),
    .vec_data(vec_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status)
  );

  int total = 0;
  int bad = 0;

  function automatic logic [63:0] addr_of(int i);
    return {32'hA000_0000 + i, 32'h0000_1000 + (i << 4)};
  endfunction

  function automatic logic [31:0] data_of(int i);
    return 32'hC0DE_0000 + i;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit          m_pend[NV];
  int          m_state;   // 0 idle, 1 offering, 2 awaiting completion
  int          m_idx;
  logic [63:0] m_addr;
  logic [31:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_pend[i]) m_pend[i] = 0;
      m_state = 0; m_idx = 0; m_addr = '0; m_data = '0;
    end else begin
      bit ok[NV];
      bit clr;
      int pick;
      clr = 0;
      foreach (ok[i]) ok[i] = m_pend[i] && !vec_mask[i] && !func_mask && enable;
      if (m_state == 0) begin
        pick = -1;
        for (int i = NV - 1; i >= 0; i--) if (ok[i]) pick = i;
        if (pick >= 0) begin
          m_state = 1; m_idx = pick;
          m_addr = addr_of(pick); m_data = data_of(pick);
        end
      end else if (m_state == 1) begin
        if (wr_ready) m_state = 2;
      end else if (cpl_valid) begin
        if (cpl_status == 2'b01) m_state = ok[m_idx] ? 1 : 0;
        else begin clr = 1; m_state = 0; end
      end
      if (clr) m_pend[m_idx] = 0;
      for (int i = 0; i < NV; i++) if (event_pulse[i] && enable) m_pend[i] = 1;
    end
  end

  bit run_cmp = 0;
  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk(wr_valid == (m_state == 1), "R11 wr_valid vs model", wr_valid, m_state == 1);
      if (m_state == 1) begin
        chk(wr_addr == m_addr, "R2 wr_addr vs model", wr_addr, m_addr);
        chk(wr_data == m_data, "R2 wr_data vs model", wr_data, m_data);
      end
    end
  end

  // ---------------- bus target ----------------
  int  vlog[$];
  int  st_q[$];
  bit  outst = 0;
  bit  hs_seen = 0;
  bit  ready_all = 1;
  bit  rand_st = 0;
  int  cpl_dly = 1;
  int  dly = 0;
  bit  prev_stall = 0;
  logic [63:0] prev_addr;
  logic [31:0] prev_data;

  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(wr_valid && wr_addr == prev_addr && wr_data == prev_data,
            "R5 held offer", wr_data, prev_data);
      end
      prev_stall = wr_valid && !wr_ready;
      prev_addr  = wr_addr;
      prev_data  = wr_data;
      if (wr_valid && wr_ready) begin
        chk(!outst && !hs_seen, "R11 handshake while outstanding", 1, 0);
        chk(wr_be == 4'hF, "R2 byte enables", wr_be, 4'hF);
        chk(wr_addr == addr_of(int'(wr_data[7:0])), "R2 address matches vector",
            wr_addr, addr_of(int'(wr_data[7:0])));
        vlog.push_back(int'(wr_data[7:0]));
        hs_seen = 1;
      end
    end
  end

  always @(negedge clk) begin
    cpl_valid = 1'b0;
    wr_ready = ready_all ? 1'b1 : (($urandom % 3) == 0);
    if (hs_seen) begin
      hs_seen = 0; outst = 1;
      dly = rand_st ? int'($urandom % 4) : cpl_dly;
    end else if (outst) begin
      if (dly == 0) begin
        cpl_valid = 1'b1;
        if (st_q.size() > 0) cpl_status = 2'(st_q.pop_front());
        else if (rand_st) cpl_status = 2'($urandom % 4);
        else cpl_status = 2'b00;
        outst = 0;
      end else dly--;
    end
  end

  // ---------------- stimulus ----------------
  task automatic pulse(logic [NV-1:0] v);
    @(negedge clk); event_pulse = v;
    @(negedge clk); event_pulse = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    for (int i = 0; i < NV; i++) begin
      vec_addr[i*AW +: AW] = addr_of(i);
      vec_data[i*DW +: DW] = data_of(i);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1; enable = 1'b1; run_cmp = 1;

    // R1: quiet after reset
    @(negedge clk);
    chk(!wr_valid, "R1 idle after reset", wr_valid, 0);
    idle(10);
    chk(vlog.size() == 0, "R1 no write without events", vlog.size(), 0);

    // R2: single unmasked event
    pulse(8'h08); idle(20);
    chk(vlog.size() == 1 && vlog[0] == 3, "R2 one write for vector 3", vlog.size(), 1);

    // R3/R4: own mask then release
    base = vlog.size();
    vec_mask[5] = 1'b1; pulse(8'h20); idle(20);
    chk(vlog.size() == base, "R3 masked vector silent", vlog.size(), base);
    vec_mask[5] = 1'b0; idle(20);
    chk(vlog.size() == base + 1 && vlog[base] == 5, "R4 replay after unmask", vlog.size(), base + 1);

    // R3/R6: function mask over two vectors, then ordered replay
    base = vlog.size();
    func_mask = 1'b1; pulse(8'h44); idle(20);
    chk(vlog.size() == base, "R3 function mask silences all", vlog.size(), base);
    func_mask = 1'b0; idle(30);
    chk(vlog.size() == base + 2 && vlog[base] == 2 && vlog[base+1] == 6,
        "R4 function-mask replay order", vlog.size(), base + 2);

    // R6: simultaneous events served lowest first
    base = vlog.size();
    pulse(8'h92); idle(40);
    chk(vlog.size() == base + 3 && vlog[base] == 1 && vlog[base+1] == 4 && vlog[base+2] == 7,
        "R6 lowest index first", vlog.size(), base + 3);

    // R7: retry twice then normal
    base = vlog.size();
    st_q = '{1, 1, 0}; pulse(8'h01); idle(40);
    chk(vlog.size() == base + 3 && vlog[base+2] == 0, "R7 retry re-offers same vector",
        vlog.size(), base + 3);

    // R8: aborts count as sent
    base = vlog.size();
    st_q = '{2}; pulse(8'h02); idle(20);
    st_q = '{3}; pulse(8'h02); idle(30);
    chk(vlog.size() == base + 2, "R8 master/target abort complete once", vlog.size(), base + 2);

    // R9: events dropped while disabled
    base = vlog.size();
    enable = 1'b0; pulse(8'h08); idle(5);
    enable = 1'b1; idle(20);
    chk(vlog.size() == base, "R9 disabled event dropped", vlog.size(), base);
    vec_mask[4] = 1'b1; pulse(8'h10); enable = 1'b0; vec_mask[4] = 1'b0; idle(20);
    chk(vlog.size() == base, "R9 no send while disabled", vlog.size(), base);
    enable = 1'b1; idle(20);
    chk(vlog.size() == base + 1 && vlog[base] == 4, "R9 kept pending sent on enable",
        vlog.size(), base + 1);

    // R10: repeated events while masked merge
    base = vlog.size();
    vec_mask[2] = 1'b1;
    pulse(8'h04); pulse(8'h04); pulse(8'h04);
    vec_mask[2] = 1'b0; idle(30);
    chk(vlog.size() == base + 1, "R10 merged events give one write", vlog.size(), base + 1);

    // R5/R11: stalled channel with several vectors
    base = vlog.size();
    ready_all = 0; pulse(8'hFF); idle(200);
    chk(vlog.size() == base + 8, "R5 all vectors delivered under back-pressure", vlog.size(), base + 8);

    // randomized phase against the reference
    rand_st = 1;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      event_pulse = NV'($urandom & $urandom & $urandom);
      if (($urandom % 12) == 0) vec_mask[$urandom % NV] ^= 1'b1;
      if (($urandom % 60) == 0) func_mask = ~func_mask;
      enable = (($urandom % 25) != 0);
    end
    @(negedge clk);
    event_pulse = '0; vec_mask = '0; func_mask = 1'b0; enable = 1'b1;
    rand_st = 0; ready_all = 1;
    idle(150);
    chk(!wr_valid && m_state == 0, "R10 drained after random phase", wr_valid, 0);

    run_cmp = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule